// File: doc/BRIEF.md
# Shared Connector Pin Router for Printer and External Floppy

This block owns a group of pins on the printer connector and hands them, at run time, either to the parallel-port core or to a second floppy-controller interface. A detect pin from the connector tells which kind of device is attached. A two-bit mode field says whether routing is automatic and how the detect level is read. The detect pin passes through a two-flop synchronizer and a debounce filter. A printer can therefore be swapped for an external drive, or back, with the power on.

A status bit shows which function owns the pins. It can be read in the configuration byte, and writes to it have no effect. When the floppy side owns the pins, the parallel-port core sees only idle inputs. When the parallel side owns them, the floppy core sees only idle inputs. Each time ownership changes, every shared output enable is held off for one clock so that the two sides never drive the pins at the same time. A swap control decides which floppy drive select goes to the internal header and which goes to the shared connector.

Top module: `ppfdd_pin_router`

## Requirements
- R1: After reset the configuration byte reads 0x80: mode 00, swap 0, status 1, and the parallel-port core owns the pins.
- R2: With mode 00 (bits 6:5), the status bit (bit 7) is 1 and the parallel-port core owns the pins, whatever the detect pin level.
- R3: The mode field sets the status from the filtered detect level `d`:
  - 01 gives status = d.
  - 10 gives status = not d.
  - 11 gives status 0.
  - Status 1 means the parallel-port core owns the pins. Status 0 means the floppy core owns them.
- R4: With status 0, the following hold:
  - `pin_out` and `pin_oe` come from the floppy core.
  - `fd_in` equals `pin_in`.
  - `pp_in` is held at all ones.
- R5: With status 1, the following hold:
  - `pin_out` and `pin_oe` come from the parallel-port core.
  - `pp_in` equals `pin_in`.
  - `fd_in` is held at all ones.
- R6: Writes to bit 7 are ignored. Reads of bit 7 return the live status. Bits 4:1 read 0.
- R7: The detect pin is synchronized through two flops. A new level takes effect only after the synchronized value has differed from the filtered value for DEB consecutive clocks. Shorter pulses have no effect.
- R8: In the first clock after ownership changes, for any reason, `pin_oe` is all zeros.
- R9: Bit 0 is the swap control. With swap 0, `hdr_drv` = `fdc_drv_a` and the shared select uses `fdc_drv_b`. With swap 1, the two are exchanged.
- R10: `shr_drv` is 0 whenever the parallel-port core owns the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data: bit 7 status, bits 6:5 mode, bit 0 swap |
| det_pin | input | 1 | Device-detect pin from the connector |
| pin_in | input | W | Levels seen on the shared pins |
| pin_out | output | W | Levels driven to the shared pins |
| pin_oe | output | W | Output enables for the shared pins |
| pp_out | input | W | Parallel-port core output data |
| pp_oe | input | W | Parallel-port core output enables |
| pp_in | output | W | Pin inputs presented to the parallel-port core |
| fd_out | input | W | Floppy core output data for the shared pins |
| fd_oe | input | W | Floppy core output enables for the shared pins |
| fd_in | output | W | Pin inputs presented to the floppy core |
| fdc_drv_a | input | 1 | Floppy core select for drive A |
| fdc_drv_b | input | 1 | Floppy core select for drive B |
| hdr_drv | output | 1 | Drive select routed to the internal header |
| shr_drv | output | 1 | Drive select routed to the shared connector |

## Verification
The bench aims detect pulses of two clocks at the filter. A filter that is too short, or that never resets its count, would let such a pulse hand the pins to the wrong core. It changes ownership through the detect pin, through mode writes and through the forced mode. A missing or misplaced blank cycle would show as an enable asserted in the first clock after a change. It writes bit 7 with both values and sweeps every mode. This catches a writable status bit, an inverted polarity decode or a mode 00 that still follows the detect pin. The idle value on the unselected input bus and the swapped drive selects are compared every clock against the reference model.

// File: rtl/ppfdd_pkg.sv
package ppfdd_pkg;
  typedef enum logic [1:0] {
    PM_OFF       = 2'b00,
    PM_DET_HIGH  = 2'b01,
    PM_DET_LOW   = 2'b10,
    PM_FORCE_FDD = 2'b11
  } pm_mode_e;

  localparam int CFG_STAT_BIT = 7;
  localparam int CFG_MODE_LO  = 5;
  localparam int CFG_SWAP_BIT = 0;

  // status 1: parallel port owns the pins, 0: floppy owns them
  function automatic logic status_of(input pm_mode_e mode, input logic det);
    case (mode)
      PM_OFF:       status_of = 1'b1;
      PM_DET_HIGH:  status_of = det;
      PM_DET_LOW:   status_of = ~det;
      default:      status_of = 1'b0;
    endcase
  endfunction

  // returns {header select, shared select}
  function automatic logic [1:0] drive_pair(input logic swap, input logic a, input logic b);
    drive_pair = swap ? {b, a} : {a, b};
  endfunction
endpackage

// File: rtl/ppfdd_cfg_reg.sv
module ppfdd_cfg_reg
  import ppfdd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       status,
  output pm_mode_e   mode,
  output logic       swap,
  output logic [7:0] rdata
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[CFG_STAT_BIT], wdata[4:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= PM_OFF;
      swap <= 1'b0;
    end else if (we) begin
      mode <= pm_mode_e'(wdata[CFG_MODE_LO +: 2]);
      swap <= wdata[CFG_SWAP_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[CFG_STAT_BIT]      = status;
    rdata[CFG_MODE_LO +: 2]  = mode;
    rdata[CFG_SWAP_BIT]      = swap;
  end
endmodule

// File: rtl/ppfdd_det_filter.sv
module ppfdd_det_filter #(
  parameter int DEB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_pin,
  output logic det_sync,
  output logic det_filt
);
  localparam int CW = $clog2(DEB + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB - 1);

  logic          s1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1       <= 1'b1;
      det_sync <= 1'b1;
    end else begin
      s1       <= det_pin;
      det_sync <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_filt <= 1'b1;
      cnt      <= '0;
    end else if (det_sync != det_filt) begin
      if (cnt == LAST) begin
        det_filt <= det_sync;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/ppfdd_route.sv
module ppfdd_route #(
  parameter int W = 8,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         own_fdd,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] pp_out,
  input  logic [W-1:0] pp_oe,
  input  logic [W-1:0] fd_out,
  input  logic [W-1:0] fd_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pp_in,
  output logic [W-1:0] fd_in,
  output logic         blank
);
  logic own_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= 1'b0;
    else        own_q <= own_fdd;
  end

  assign blank = own_fdd ^ own_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pin_out[i] = own_fdd ? fd_out[i] : pp_out[i];
    assign pin_oe[i]  = ~blank & (own_fdd ? fd_oe[i] : pp_oe[i]);
    assign pp_in[i]   = own_fdd ? IDLE[i] : pin_in[i];
    assign fd_in[i]   = own_fdd ? pin_in[i] : IDLE[i];
  end
endmodule

// File: rtl/ppfdd_pin_router.sv
module ppfdd_pin_router
  import ppfdd_pkg::*;
#(
  parameter int W   = 8,
  parameter int DEB = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [7:0]   cfg_wdata,
  output logic [7:0]   cfg_rdata,
  input  logic         det_pin,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic [W-1:0] pp_out,
  input  logic [W-1:0] pp_oe,
  output logic [W-1:0] pp_in,
  input  logic [W-1:0] fd_out,
  input  logic [W-1:0] fd_oe,
  output logic [W-1:0] fd_in,
  input  logic         fdc_drv_a,
  input  logic         fdc_drv_b,
  output logic         hdr_drv,
  output logic         shr_drv
);
  pm_mode_e   mode;
  logic       swap;
  logic       status;
  logic       own_fdd;
  logic       det_sync;
  logic       det_filt;
  logic       blank;
  logic [1:0] drv;

  ppfdd_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .status(status), .mode(mode), .swap(swap), .rdata(cfg_rdata)
  );

  ppfdd_det_filter #(.DEB(DEB)) u_det (
    .clk(clk), .rst_n(rst_n), .det_pin(det_pin),
    .det_sync(det_sync), .det_filt(det_filt)
  );

  assign status  = status_of(mode, det_filt);
  assign own_fdd = ~status;

  ppfdd_route #(.W(W)) u_route (
    .clk(clk), .rst_n(rst_n), .own_fdd(own_fdd), .pin_in(pin_in),
    .pp_out(pp_out), .pp_oe(pp_oe), .fd_out(fd_out), .fd_oe(fd_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .pp_in(pp_in), .fd_in(fd_in),
    .blank(blank)
  );

  assign drv     = drive_pair(swap, fdc_drv_a, fdc_drv_b);
  assign hdr_drv = drv[1];
  assign shr_drv = own_fdd & drv[0];
endmodule

// File: rtl/ppfdd_checker.sv
module ppfdd_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         own_fdd,
  input logic         det_sync,
  input logic         det_filt,
  input logic         swap,
  input logic [7:0]   cfg_rdata,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pp_in,
  input logic [W-1:0] fd_in,
  input logic         fdc_drv_a,
  input logic         hdr_drv,
  input logic         shr_drv
);
  p_mode_off_parallel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[6:5] == 2'b00) |-> (cfg_rdata[7] && !own_fdd));

  p_floppy_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    own_fdd |-> (pp_in == '1));

  p_parallel_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !own_fdd |-> (fd_in == '1));

  p_filter_takes_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(det_filt) |-> (det_filt == $past(det_sync)));

  p_oe_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(own_fdd) |-> (pin_oe == '0));

  p_drive_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |-> (hdr_drv == fdc_drv_a));

  p_shared_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !own_fdd |-> !shr_drv);
endmodule

bind ppfdd_pin_router ppfdd_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .own_fdd(own_fdd), .det_sync(det_sync),
  .det_filt(det_filt), .swap(swap), .cfg_rdata(cfg_rdata), .pin_oe(pin_oe),
  .pp_in(pp_in), .fd_in(fd_in), .fdc_drv_a(fdc_drv_a), .hdr_drv(hdr_drv),
  .shr_drv(shr_drv)
);

// File: tb/ppfdd_pin_router_tb.sv
module ppfdd_pin_router_tb;
  localparam int W   = 8;
  localparam int DEB = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_wdata = 0;
  logic [7:0] cfg_rdata;
  logic det_pin = 1;
  logic [W-1:0] pin_in = 0, pp_out = 0, pp_oe = 0, fd_out = 0, fd_oe = 0;
  logic [W-1:0] pin_out, pin_oe, pp_in, fd_in;
  logic fdc_drv_a = 0, fdc_drv_b = 0, hdr_drv, shr_drv;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ppfdd_pin_router #(.W(W), .DEB(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .det_pin(det_pin), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pp_out(pp_out), .pp_oe(pp_oe),
    .pp_in(pp_in), .fd_out(fd_out), .fd_oe(fd_oe), .fd_in(fd_in),
    .fdc_drv_a(fdc_drv_a), .fdc_drv_b(fdc_drv_b), .hdr_drv(hdr_drv),
    .shr_drv(shr_drv)
  );

  // reference model: plain integers
  int m_mode, m_swap, m_q1, m_q2, m_filt, m_run, m_prev_fdd;

  function automatic int exp_status();
    if (m_mode == 0) return 1;
    if (m_mode == 1) return m_filt;
    if (m_mode == 2) return (m_filt == 0) ? 1 : 0;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_swap = 0; m_q1 = 1; m_q2 = 1; m_filt = 1; m_run = 0; m_prev_fdd = 0;
    end else begin
      m_prev_fdd = 1 - exp_status();
      if (m_q2 != m_filt) begin
        m_run = m_run + 1;
        if (m_run >= DEB) begin m_filt = m_q2; m_run = 0; end
      end else m_run = 0;
      m_q2 = m_q1;
      m_q1 = int'(det_pin);
      if (cfg_we) begin
        m_mode = int'(cfg_wdata[6:5]);
        m_swap = int'(cfg_wdata[0]);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int st, fdd, blank;
    logic [W-1:0] oe_e;
    logic hd, sd;
    st = exp_status();
    fdd = 1 - st;
    blank = (fdd != m_prev_fdd);
    chk(m_mode == 0 ? "R2 status" : "R3 status", 32'(cfg_rdata[7]), 32'(st));
    chk("R6 rdata", 32'(cfg_rdata), 32'({st[0], m_mode[1:0], 4'b0, m_swap[0]}));
    oe_e = blank ? '0 : (fdd != 0 ? fd_oe : pp_oe);
    chk(blank ? "R8 blank oe" : (fdd != 0 ? "R4 oe" : "R5 oe"), 32'(pin_oe), 32'(oe_e));
    if (fdd != 0) begin
      chk("R4 pin_out", 32'(pin_out), 32'(fd_out));
      chk("R4 fd_in", 32'(fd_in), 32'(pin_in));
      chk("R4 pp_in idle", 32'(pp_in), 32'({W{1'b1}}));
    end else begin
      chk("R5 pin_out", 32'(pin_out), 32'(pp_out));
      chk("R5 pp_in", 32'(pp_in), 32'(pin_in));
      chk("R5 fd_in idle", 32'(fd_in), 32'({W{1'b1}}));
    end
    hd = (m_swap != 0) ? fdc_drv_b : fdc_drv_a;
    sd = (m_swap != 0) ? fdc_drv_a : fdc_drv_b;
    chk("R9 hdr_drv", 32'(hdr_drv), 32'(hd));
    chk(fdd != 0 ? "R9 shr_drv" : "R10 shr_drv", 32'(shr_drv), 32'(fdd != 0 ? sd : 1'b0));
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      pin_in = W'($urandom); pp_out = W'($urandom); pp_oe = W'($urandom);
      fd_out = W'($urandom); fd_oe = W'($urandom);
      fdc_drv_a = 1'($urandom); fdc_drv_b = 1'($urandom);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v;
    step(1);
    cfg_we = 0; cfg_wdata = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset rdata", 32'(cfg_rdata), 32'h80);
    chk("R1 reset fd_in idle", 32'(fd_in), 32'({W{1'b1}}));
    step(3);
    // R2: mode 00 ignores detect
    det_pin = 0; step(12);
    det_pin = 1; step(3);
    det_pin = 0; step(10);
    chk("R2 status with detect low", 32'(cfg_rdata[7]), 32'h1);
    // R6: bit 7 written as 1 with mode 01, detect still low
    wr(8'hA0); step(2);
    chk("R6 status live", 32'(cfg_rdata[7]), 32'h0);
    // R7: two-clock pulse must not switch ownership
    det_pin = 1; step(2);
    det_pin = 0; step(10);
    chk("R7 pulse ignored", 32'(cfg_rdata[7]), 32'h0);
    det_pin = 1; step(12);
    chk("R7 long level taken", 32'(cfg_rdata[7]), 32'h1);
    det_pin = 0; step(3);
    det_pin = 1; step(8);
    // R3: inverted polarity, then forced floppy, with swap
    wr(8'h40); step(6);
    det_pin = 0; step(12);
    wr(8'hE1); step(8);
    det_pin = 1; step(10);
    wr(8'h21); step(8);
    wr(8'h01); step(6);
    wr(8'h60); step(4);
    wr(8'h00); step(4);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule